// File: doc/BRIEF.md
# Start/Stop Gated Trace Window Buffer

This block is a small on-chip circular memory that keeps processor status records for a debugger. An arm pulse clears it and puts it in the armed state. Three kinds of recording are offered. In start/stop mode, the start event opens the recording window and the stop event closes it, and each event is taken from one of two execution-address comparator hits or a data-access comparator hit. In continuous mode, the buffer records and wraps from the moment it is armed until the processor halts. In trigger-window mode, the buffer records and wraps until a trigger arrives, then stores a post-trigger count, so the trigger ends up near the start, in the middle or near the end of the retained window.

Readout is possible only after recording has finished. Each read request returns one record, starting with the oldest one kept and moving forward through the buffer.

Top module: `trace_window_buf`

## Requirements
- R1: During synchronous reset (rst_n low) the state output becomes idle (2'b00) and rd_valid becomes 0. The state field is encoded as idle 00, armed 01, sampling 10 and done 11.
- R2: An arm pulse in any state gives the armed state on the next cycle. It also discards every record kept before, so a later readout returns only records stored after that arm.
- R3: pair_sel chooses the event pair. 0 is start on data_hit and stop on bp1_hit. 1 is start on data_hit and stop on bp0_hit. 2 is start on bp0_hit and stop on data_hit. 3 is start on bp0_hit and stop on bp1_hit. A hit that is not part of the selected pair has no effect.
- R4: The mode input is encoded as 0 start/stop, 1 continuous, 2 trigger-window, with 3 acting as start/stop. In start/stop mode, a record with rec_valid high is stored in every cycle from the start-event cycle up to and including the stop-event cycle. Nothing is stored while armed before the start, and a stop event seen while armed is ignored.
- R5: While the state is sampling, rd_req has no effect and rd_valid stays 0.
- R6: In continuous mode, recording begins in the first armed cycle. It ends with the state becoming done after a cycle in which cpu_halted is high, and the record of that cycle is stored. Once more than 64 records have been stored, only the last 64 are kept.
- R7: In trigger-window mode, recording begins in the first armed cycle and the trigger is the selected pair's stop event, seen while sampling. After the trigger record, trig_pos 0 stores 63 further records, trig_pos 1 and 3 store 31 further records, and trig_pos 2 stores none. The state becomes done on the last of these records.
- R8: In the done state, rd_valid is high one cycle after a rd_req cycle. rd_data then holds the records in storage order, beginning with the oldest one kept, and each request moves to the next record.
- R9: The done state holds until the next arm pulse, and records offered while done are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Clear the buffer and enter the armed state |
| mode | input | 2 | Recording mode |
| pair_sel | input | 2 | Start/stop (or trigger) event pair |
| trig_pos | input | 2 | Trigger placement in trigger-window mode |
| bp0_hit | input | 1 | Execution comparator 0 match |
| bp1_hit | input | 1 | Execution comparator 1 match |
| data_hit | input | 1 | Data-access comparator match |
| cpu_halted | input | 1 | Processor has stopped |
| rec_valid | input | 1 | A status record is offered this cycle |
| rec_data | input | 8 | Status record |
| rd_req | input | 1 | Debug read request |
| state | output | 2 | Recording state |
| rd_valid | output | 1 | rd_data holds a returned record |
| rd_data | output | 8 | Returned record |

## Verification
Every event, halt, trigger or arm that is sampled on a rising edge shows on the state output right after that edge. A record returned for a read request appears, together with rd_valid, one edge after the request. The bench's reference model takes the same inputs at each rising edge and updates its own expected state, record queue and read result. Inputs change and outputs are compared only on falling edges, so every comparison lands in the exact cycle in which a result is due.

// File: rtl/twb_pkg.sv
// Shared encodings for the trace window buffer.
// Assumes: the state and mode encodings are visible at the block's ports.
package twb_pkg;
    typedef enum logic [1:0] {
        TW_IDLE  = 2'b00,
        TW_ARMED = 2'b01,
        TW_SAMP  = 2'b10,
        TW_DONE  = 2'b11
    } tw_state_e;

    typedef enum logic [1:0] {
        TM_STARTSTOP = 2'b00,
        TM_CONT      = 2'b01,
        TM_TRIG      = 2'b10,
        TM_ALT       = 2'b11
    } tw_mode_e;
endpackage

// File: rtl/twb_evsel.sv
// Event selector: maps the three comparator hits onto a start event and a
// stop event, following the selected pair code.
// Assumes: the hits are single-cycle, already synchronous to clk.
module twb_evsel (
    input  logic [1:0] pair_sel,
    input  logic       bp0_hit,
    input  logic       bp1_hit,
    input  logic       data_hit,
    output logic       start_ev,
    output logic       stop_ev
);
    // Pick the start and stop sources for the pair code.
    always_comb begin
        case (pair_sel)
            2'd0:    begin start_ev = data_hit; stop_ev = bp1_hit;  end
            2'd1:    begin start_ev = data_hit; stop_ev = bp0_hit;  end
            2'd2:    begin start_ev = bp0_hit;  stop_ev = data_hit; end
            default: begin start_ev = bp0_hit;  stop_ev = bp1_hit;  end
        endcase
    end
endmodule

// File: rtl/twb_ctrl.sv
// Recording controller: the state machine that decides when records are
// stored and when recording ends, plus the post-trigger counter.
// Assumes: DEPTH is a power of two, at least 4.
module twb_ctrl
    import twb_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic [1:0] mode,
    input  logic [1:0] trig_pos,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic       cpu_halted,
    input  logic       rec_valid,
    output tw_state_e  state,
    output logic       wr_en,
    output logic       clear
);
    localparam int CW = $clog2(DEPTH);
    localparam logic [CW-1:0] POST_BEGIN  = CW'(DEPTH - 1);
    localparam logic [CW-1:0] POST_CENTRE = CW'(DEPTH / 2 - 1);
    localparam logic [CW-1:0] POST_END    = '0;

    tw_state_e     st_q;
    logic          trig_seen_q;
    logic [CW-1:0] post_left_q;
    logic [CW-1:0] post_init;
    logic          start_go;
    tw_mode_e      mode_e;

    assign mode_e = tw_mode_e'(mode);

    // Post-trigger record count for the chosen trigger placement.
    always_comb begin
        case (trig_pos)
            2'd0:    post_init = POST_BEGIN;
            2'd2:    post_init = POST_END;
            default: post_init = POST_CENTRE;
        endcase
    end

    // Free-running modes begin at once; start/stop mode waits for its event.
    assign start_go = (mode_e == TM_CONT) || (mode_e == TM_TRIG) || start_ev;

    // Store a record while armed-and-starting or while sampling.
    assign wr_en = !arm && rec_valid &&
                   (((st_q == TW_ARMED) && start_go) || (st_q == TW_SAMP));
    assign clear = arm;
    assign state = st_q;

    // State machine and post-trigger countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= TW_IDLE;
            trig_seen_q <= 1'b0;
            post_left_q <= '0;
        end else if (arm) begin
            st_q        <= TW_ARMED;
            trig_seen_q <= 1'b0;
            post_left_q <= '0;
        end else begin
            case (st_q)
                TW_ARMED: if (start_go) st_q <= TW_SAMP;
                TW_SAMP: begin
                    case (mode_e)
                        TM_CONT: if (cpu_halted) st_q <= TW_DONE;
                        TM_TRIG: begin
                            if (!trig_seen_q && stop_ev) begin
                                if (post_init == '0) begin
                                    st_q <= TW_DONE;
                                end else begin
                                    trig_seen_q <= 1'b1;
                                    post_left_q <= post_init;
                                end
                            end else if (trig_seen_q && rec_valid) begin
                                post_left_q <= post_left_q - 1'b1;
                                if (post_left_q == CW'(1)) st_q <= TW_DONE;
                            end
                        end
                        default: if (stop_ev) st_q <= TW_DONE;
                    endcase
                end
                default: st_q <= st_q;
            endcase
        end
    end

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TW_DONE && !arm) |=> (st_q == TW_DONE));
    // R2
    arm_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (st_q == TW_ARMED));
    // R4
    armed_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TW_ARMED && !arm) |=> (st_q != TW_DONE));
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (st_q == TW_IDLE));
endmodule

// File: rtl/twb_store.sv
// Record store: circular memory with write pointer, wrap flag and a read
// offset measured from the oldest record kept.
// Assumes: DEPTH is a power of two; wr_en and rd_en never both occur.
module twb_store #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr_q;
    logic             wrap_q;
    logic [AW-1:0]    roff_q;
    logic [AW-1:0]    rd_addr;

    // Oldest record is at the write pointer once the buffer has wrapped.
    assign rd_addr = (wrap_q ? wptr_q : '0) + roff_q;

    // Memory array write.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr_q] <= wr_data;
    end

    // Write pointer, wrap flag and read offset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr_q <= '0;
            wrap_q <= 1'b0;
            roff_q <= '0;
        end else begin
            if (wr_en) begin
                wptr_q <= wptr_q + 1'b1;
                if (wptr_q == AW'(DEPTH - 1)) wrap_q <= 1'b1;
            end
            if (rd_en) roff_q <= roff_q + 1'b1;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= mem[rd_addr];
        end
    end

    // R6
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_q && !clear) |=> wrap_q);
endmodule

// File: rtl/trace_window_buf.sv
// Trace window buffer top: ties the event selector, recording controller
// and record store together; reads are granted only when recording is done.
// Assumes: comparators and transport live outside this block.
module trace_window_buf
    import twb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [1:0]       mode,
    input  logic [1:0]       pair_sel,
    input  logic [1:0]       trig_pos,
    input  logic             bp0_hit,
    input  logic             bp1_hit,
    input  logic             data_hit,
    input  logic             cpu_halted,
    input  logic             rec_valid,
    input  logic [WIDTH-1:0] rec_data,
    input  logic             rd_req,
    output logic [1:0]       state,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data
);
    logic      start_ev, stop_ev;
    logic      wr_en, clear, rd_en;
    tw_state_e st;

    twb_evsel u_evsel (
        .pair_sel (pair_sel),
        .bp0_hit  (bp0_hit),
        .bp1_hit  (bp1_hit),
        .data_hit (data_hit),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    twb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .mode       (mode),
        .trig_pos   (trig_pos),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .cpu_halted (cpu_halted),
        .rec_valid  (rec_valid),
        .state      (st),
        .wr_en      (wr_en),
        .clear      (clear)
    );

    // Reads are only honoured once recording has finished.
    assign rd_en = rd_req && (st == TW_DONE);

    twb_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .wr_en    (wr_en),
        .wr_data  (rec_data),
        .rd_en    (rd_en),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign state = st;

    // R8
    rd_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(state) == 2'b11));
    // R5
    no_read_sampling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b10) |=> !rd_valid);
endmodule

// File: tb/trace_window_buf_tb.sv
// Bench: behavioural reference model updated on each rising edge, compared
// with the design on each falling edge.
module trace_window_buf_tb;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [1:0] pair_sel = 2'd0;
    logic [1:0] trig_pos = 2'd0;
    logic       bp0_hit = 1'b0, bp1_hit = 1'b0, data_hit = 1'b0;
    logic       cpu_halted = 1'b0;
    logic       rec_valid = 1'b0;
    logic [7:0] rec_data = 8'd0;
    logic       rd_req = 1'b0;
    logic [1:0] state;
    logic       rd_valid;
    logic [7:0] rd_data;

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // Reference model state.
    int  m_st = 0;
    int  q[$];
    int  m_off = 0;
    bit  m_trig = 1'b0;
    int  m_post = 0;
    bit  e_rv = 1'b0;
    int  e_rd = 0;
    bit  started = 1'b0;

    trace_window_buf u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .pair_sel(pair_sel),
        .trig_pos(trig_pos), .bp0_hit(bp0_hit), .bp1_hit(bp1_hit),
        .data_hit(data_hit), .cpu_halted(cpu_halted), .rec_valid(rec_valid),
        .rec_data(rec_data), .rd_req(rd_req), .state(state),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    function automatic bit ev_start();
        case (pair_sel)
            2'd0, 2'd1: return data_hit;
            default:    return bp0_hit;
        endcase
    endfunction

    function automatic bit ev_stop();
        case (pair_sel)
            2'd0:    return bp1_hit;
            2'd1:    return bp0_hit;
            2'd2:    return data_hit;
            default: return bp1_hit;
        endcase
    endfunction

    function automatic int post_count();
        case (trig_pos)
            2'd0:    return DEPTH - 1;
            2'd2:    return 0;
            default: return DEPTH / 2 - 1;
        endcase
    endfunction

    task automatic push(int v);
        q.push_back(v);
        if (q.size() > DEPTH) void'(q.pop_front());
    endtask

    // Reference model, following the requirements.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_st = 0; q.delete(); m_off = 0; m_trig = 0; m_post = 0; e_rv = 0; e_rd = 0;
        end else begin
            e_rv = 0;
            if (m_st == 3 && rd_req) begin
                e_rv = 1;
                e_rd = q[m_off % q.size()];
                m_off++;
            end
            if (arm) begin
                m_st = 1; q.delete(); m_off = 0; m_trig = 0; m_post = 0;
            end else if (m_st == 1) begin
                if (mode == 2'd1 || mode == 2'd2 || ev_start()) begin
                    if (rec_valid) push(int'(rec_data));
                    m_st = 2;
                end
            end else if (m_st == 2) begin
                if (rec_valid) push(int'(rec_data));
                if (mode == 2'd1) begin
                    if (cpu_halted) m_st = 3;
                end else if (mode == 2'd2) begin
                    if (!m_trig && ev_stop()) begin
                        if (post_count() == 0) m_st = 3;
                        else begin m_trig = 1; m_post = post_count(); end
                    end else if (m_trig && rec_valid) begin
                        m_post--;
                        if (m_post == 0) m_st = 3;
                    end
                end else if (ev_stop()) begin
                    m_st = 3;
                end
            end
        end
    end

    // Compare on each falling edge.
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (int'(state) != m_st) begin
                fails++;
                $display("FAIL %s state actual=%0d expected=%0d t=%0t", cur_req, state, m_st, $time);
            end
            checks++;
            if (rd_valid != e_rv) begin
                fails++;
                $display("FAIL %s rd_valid actual=%0d expected=%0d t=%0t", cur_req, rd_valid, e_rv, $time);
            end else if (e_rv) begin
                checks++;
                if (int'(rd_data) != e_rd) begin
                    fails++;
                    $display("FAIL %s rd_data actual=%0h expected=%0h t=%0t", cur_req, rd_data, e_rd, $time);
                end
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog all-reqs cycles actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    task automatic tick();
        @(negedge clk);
        arm = 0; bp0_hit = 0; bp1_hit = 0; data_hit = 0; cpu_halted = 0; rd_req = 0;
        rec_data = rec_data + 8'd1;
    endtask

    task automatic do_arm();
        tick(); arm = 1;
        tick();
    endtask

    task automatic read_all();
        int n;
        n = q.size();
        for (int i = 0; i < n; i++) begin
            tick(); rd_req = 1;
        end
        tick(); tick();
    endtask

    task automatic run_recs(int n);
        for (int i = 0; i < n; i++) begin
            tick(); rec_valid = (i % 3) != 2;
        end
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) tick();
        rst_n = 1;
        tick(); tick();

        // R3 R4: pair 0, data start, bp1 stop; bp0 ignored; stop in armed ignored
        cur_req = "R4"; mode = 2'd0; pair_sel = 2'd0;
        do_arm();
        tick(); rec_valid = 1; bp1_hit = 1;
        run_recs(3);
        tick(); data_hit = 1;
        run_recs(4);
        cur_req = "R5";
        tick(); rd_req = 1;
        cur_req = "R3";
        tick(); bp0_hit = 1;
        run_recs(2);
        tick(); bp1_hit = 1;
        cur_req = "R9";
        run_recs(5);
        cur_req = "R8";
        read_all();

        // R3: pairs 1 and 2
        for (int p = 1; p < 3; p++) begin
            cur_req = "R3"; pair_sel = 2'(p);
            do_arm();
            tick(); rec_valid = 1; bp1_hit = 1;
            run_recs(2);
            tick(); if (p == 1) data_hit = 1; else bp0_hit = 1;
            run_recs(3);
            tick(); bp1_hit = 1;
            run_recs(2);
            tick(); if (p == 1) bp0_hit = 1; else data_hit = 1;
            cur_req = "R8";
            read_all();
        end

        // R4: mode code 3, pair 3, start and stop together while armed
        cur_req = "R4"; mode = 2'd3; pair_sel = 2'd3;
        do_arm();
        tick(); bp0_hit = 1; bp1_hit = 1; rec_valid = 1;
        run_recs(6);
        tick(); bp1_hit = 1;
        read_all();

        // R2: re-arm while sampling discards the earlier records
        cur_req = "R2";
        do_arm();
        tick(); bp0_hit = 1;
        run_recs(5);
        do_arm();
        tick(); bp0_hit = 1; rec_valid = 1;
        run_recs(3);
        tick(); bp1_hit = 1;
        read_all();

        // R6: continuous mode, wraps, stops on halt
        cur_req = "R6"; mode = 2'd1; pair_sel = 2'd0;
        do_arm();
        for (int i = 0; i < 110; i++) begin
            tick(); rec_valid = 1; bp1_hit = (i % 7) == 0;
        end
        tick(); cpu_halted = 1; rec_valid = 1;
        cur_req = "R8";
        read_all();

        // R7: trigger-window placements
        for (int tp = 0; tp < 3; tp++) begin
            cur_req = "R7"; mode = 2'd2; pair_sel = 2'd0; trig_pos = 2'(tp);
            do_arm();
            run_recs(20 + tp * 30);
            tick(); bp1_hit = 1; rec_valid = 1;
            for (int i = 0; i < 120 && m_st != 3; i++) begin
                tick(); rec_valid = (i % 4) != 3; bp1_hit = 1;
            end
            tick(); rec_valid = 0;
            cur_req = "R8";
            read_all();
        end

        tick();
        finish_run();
    end
endmodule